// File: doc/BRIEF.md
# Strip Trigger Primitive Filter

This block turns the raw samples of one strip of five calorimeter crystals into a trigger primitive, once per bunch crossing. Every crystal delivers a 12-bit ADC word plus a 2-bit code that names which of four preamplifier gains produced it. The block first converts each crystal to an 18-bit linear energy. It does this by scaling the ADC word with a programmable factor chosen by the gain code and removing that crystal's pedestal. It then adds the five crystals into a strip energy and shapes that sum with a five-tap FIR filter.

A peak finder marks the one bunch crossing where the filtered pulse reaches its maximum. Only in that crossing does the block report a non-zero energy. A fine-grain veto bit goes with the peak. It tells whether a single crystal carried at least a programmable energy.

Every result leaves the block a fixed number of clock cycles after its sample, whatever the data. Downstream tower logic can therefore line up strips by counting cycles. The gain factors are normally loaded with the ratios 1, 5, 9 and 33. All configuration inputs are static words that are held while samples flow.

Top module: `stf_strip_tpg`

## Requirements
- R1: Each crystal's linear value is adc × G − P, clamped to the range 0 to 2^18−1. G is the 6-bit unsigned factor at bits [6·c+5 : 6·c] of `gain_coef`, where c is the crystal's 2-bit gain code. P is that crystal's 12-bit pedestal at bits [12·i+11 : 12·i] of `pedestal`. A value below the pedestal gives 0.
- R2: The strip energy s(n) of a sample is the plain sum of its five linear crystal values. Crystal i is the field at bits [12·i+11 : 12·i] of `adc_in` and [2·i+1 : 2·i] of `gain_in`.
- R3: The filter output is y(n) = Σ c_k · s(n−k) for k = 0..4, at full precision. c_k is the signed two's-complement byte at bits [8·k+7 : 8·k] of `fir_coef`, and k = 0 is the newest sample.
- R4: Sample n is flagged as a peak exactly when y(n−1) < y(n) and y(n) ≥ y(n+1). On a flat top only the first sample of the plateau is flagged.
- R5: Two consecutive output cycles never both carry a peak flag.
- R6: `tp_energy` is 0 in every cycle without a peak. In a peak cycle it equals y(n) clamped to 0 when y(n) is negative and to 2^18−1 when y(n) is larger.
- R7: `tp_fgv` is 1 only in a peak cycle. It is 1 when the largest single linear crystal value of that same sample is at least `fgv_thresh`.
- R8: The peak flag, energy and veto for the sample captured at clock edge k appear on the outputs right after edge k+7, which is eight register stages. The delay is the same for all data.
- R9: While `rst_n` is low all outputs are 0 and the sample history is cleared. For the first eight edges after release, the outputs stay 0 when the inputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_in | input | 60 | Five 12-bit crystal ADC words, crystal i at [12i+11:12i] |
| gain_in | input | 10 | Five 2-bit gain codes, crystal i at [2i+1:2i] |
| gain_coef | input | 24 | Four 6-bit unsigned gain factors indexed by gain code |
| pedestal | input | 60 | Five 12-bit per-crystal pedestals |
| fir_coef | input | 40 | Five signed 8-bit filter taps, tap 0 applies to the newest sample |
| fgv_thresh | input | 18 | Single-crystal energy threshold for the veto bit |
| tp_energy | output | 18 | Filtered strip energy in a peak cycle, 0 otherwise |
| tp_peak | output | 1 | Marks the sample at the pulse maximum |
| tp_fgv | output | 1 | Fine-grain veto bit for the peak sample |

## Verification
The results move through these stages. Linearization is registered one edge after capture. The strip sum and crystal maximum come on the second edge and the filter output on the third. Because a peak needs y(n+1), the decision is taken on the fifth edge, and three more stages bring everything out after edge k+7. The bench drives sample t on a falling edge and compares the outputs against its own arithmetic model of sample t−8 on the falling edge eight iterations later. It also requires all-zero outputs during reset and in the first eight iterations after release. Each phase restarts from reset with fixed settings, so every sample's expected flag, energy and veto follow from the whole stimulus list and not from any state inside the design.

// File: rtl/stf_pkg.sv
package stf_pkg;

  // Width of the per-crystal gain selector and the number of gains it picks.
  localparam int unsigned GAIN_CODE_W = 2;
  localparam int unsigned NUM_GAINS   = 1 << GAIN_CODE_W;

  // Registers from sample capture to the registered peak decision:
  // linearize, sum, filter, one-sample look-ahead, decision.
  localparam int unsigned CORE_STAGES = 5;

  // Total fixed latency of the trigger primitive in clock cycles.
  localparam int unsigned TP_LATENCY  = 8;

endpackage

// File: rtl/stf_lin.sv
// One crystal: gain-factor multiply, pedestal removal, clamp to the linear range.
module stf_lin #(
  parameter int unsigned ADC_W     = 12,
  parameter int unsigned COEF_W    = 6,
  parameter int unsigned PED_W     = 12,
  parameter int unsigned LIN_W     = 18,
  parameter int unsigned GSEL_W    = 2,
  parameter int unsigned NUM_GAINS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADC_W-1:0]            adc,
  input  logic [GSEL_W-1:0]           gsel,
  input  logic [NUM_GAINS*COEF_W-1:0] gain_coef,
  input  logic [PED_W-1:0]            ped,
  output logic [LIN_W-1:0]            lin_q
);

  localparam int unsigned PROD_W = ADC_W + COEF_W;
  localparam int unsigned WIDE_W = (PROD_W > PED_W) ? PROD_W : PED_W;
  localparam int unsigned DIFF_W = ((WIDE_W > LIN_W) ? WIDE_W : LIN_W) + 1;
  localparam logic [LIN_W-1:0] LIN_MAX = '1;

  logic [COEF_W-1:0]        coef_sel;
  logic [PROD_W-1:0]        prod;
  logic signed [DIFF_W-1:0] diff;
  logic [LIN_W-1:0]         lin_d;

  always_comb begin
    coef_sel = gain_coef[gsel*COEF_W +: COEF_W];
    prod     = PROD_W'(adc) * PROD_W'(coef_sel);
    diff     = $signed(DIFF_W'(prod)) - $signed(DIFF_W'(ped));
    if (diff[DIFF_W-1]) begin
      lin_d = '0;
    end else if (diff > $signed(DIFF_W'(LIN_MAX))) begin
      lin_d = LIN_MAX;
    end else begin
      lin_d = diff[LIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '0;
    end else begin
      lin_q <= lin_d;
    end
  end

endmodule

// File: rtl/stf_strip_sum.sv
// Strip adder plus the largest single crystal and its veto comparison.
module stf_strip_sum #(
  parameter int unsigned NXTAL = 5,
  parameter int unsigned LIN_W = 18,
  parameter int unsigned SUM_W = 21
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NXTAL*LIN_W-1:0] lin_flat,
  input  logic [LIN_W-1:0]       fgv_thresh,
  output logic [SUM_W-1:0]       sum_q,
  output logic [LIN_W-1:0]       max_q,
  output logic                   fgv_q
);

  logic [SUM_W-1:0] sum_d;
  logic [LIN_W-1:0] max_d;
  logic             fgv_d;

  always_comb begin
    sum_d = '0;
    max_d = '0;
    for (int i = 0; i < NXTAL; i++) begin
      sum_d = sum_d + SUM_W'(lin_flat[i*LIN_W +: LIN_W]);
      if (lin_flat[i*LIN_W +: LIN_W] > max_d) begin
        max_d = lin_flat[i*LIN_W +: LIN_W];
      end
    end
    fgv_d = (max_d >= fgv_thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      max_q <= '0;
      fgv_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      max_q <= max_d;
      fgv_q <= fgv_d;
    end
  end

endmodule

// File: rtl/stf_fir.sv
// Direct-form FIR over the strip energy, full-precision signed output.
module stf_fir #(
  parameter int unsigned TAPS  = 5,
  parameter int unsigned TAP_W = 8,
  parameter int unsigned SUM_W = 21,
  parameter int unsigned Y_W   = 33
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SUM_W-1:0]        sum_in,
  input  logic                    fgv_in,
  input  logic [TAPS*TAP_W-1:0]   fir_coef,
  output logic signed [Y_W-1:0]   y_q,
  output logic                    fgv_q
);

  localparam int unsigned HIST = TAPS - 1;

  logic [SUM_W-1:0]      hist_q [HIST];
  logic [SUM_W-1:0]      hist_d [HIST];
  logic [SUM_W-1:0]      samp   [TAPS];
  logic signed [Y_W-1:0] prod   [TAPS];
  logic signed [Y_W-1:0] y_d;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [TAP_W-1:0] ck;
    logic signed [SUM_W:0]   sk;
    if (k == 0) begin : g_new
      assign samp[k] = sum_in;
    end else begin : g_old
      assign samp[k] = hist_q[k-1];
    end
    assign ck      = fir_coef[k*TAP_W +: TAP_W];
    assign sk      = {1'b0, samp[k]};
    assign prod[k] = Y_W'(ck) * Y_W'(sk);
  end

  always_comb begin
    hist_d[0] = sum_in;
    for (int k = 1; k < HIST; k++) begin
      hist_d[k] = hist_q[k-1];
    end
    y_d = '0;
    for (int k = 0; k < TAPS; k++) begin
      y_d = y_d + prod[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HIST; k++) begin
        hist_q[k] <= '0;
      end
      y_q   <= '0;
      fgv_q <= 1'b0;
    end else begin
      for (int k = 0; k < HIST; k++) begin
        hist_q[k] <= hist_d[k];
      end
      y_q   <= y_d;
      fgv_q <= fgv_in;
    end
  end

endmodule

// File: rtl/stf_peak.sv
// Local-maximum finder with energy gating, clamp and latency padding.
module stf_peak #(
  parameter int unsigned Y_W = 33,
  parameter int unsigned E_W = 18,
  parameter int unsigned PAD = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [Y_W-1:0] y_in,
  input  logic                  fgv_in,
  output logic [E_W-1:0]        tp_energy,
  output logic                  tp_peak,
  output logic                  tp_fgv
);

  localparam int unsigned DW = E_W + 2;
  localparam logic [E_W-1:0] E_MAX = '1;

  logic signed [Y_W-1:0] y_d1_q, y_d2_q;
  logic                  fgv_d1_q;
  logic                  pk;
  logic [E_W-1:0]        e_val;
  logic [DW-1:0]         dec_d, dec_q, out_w;

  always_comb begin
    pk = (y_d2_q < y_d1_q) && (y_d1_q >= y_in);
    if (!pk || y_d1_q[Y_W-1]) begin
      e_val = '0;
    end else if (y_d1_q > $signed(Y_W'(E_MAX))) begin
      e_val = E_MAX;
    end else begin
      e_val = y_d1_q[E_W-1:0];
    end
    dec_d = {pk, pk & fgv_d1_q, e_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_d1_q   <= '0;
      y_d2_q   <= '0;
      fgv_d1_q <= 1'b0;
      dec_q    <= '0;
    end else begin
      y_d1_q   <= y_in;
      y_d2_q   <= y_d1_q;
      fgv_d1_q <= fgv_in;
      dec_q    <= dec_d;
    end
  end

  if (PAD == 0) begin : g_nopad
    assign out_w = dec_q;
  end else begin : g_pad
    logic [DW-1:0] pad_q [PAD];
    logic [DW-1:0] pad_d [PAD];
    always_comb begin
      pad_d[0] = dec_q;
      for (int i = 1; i < PAD; i++) begin
        pad_d[i] = pad_q[i-1];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < PAD; i++) begin
          pad_q[i] <= '0;
        end
      end else begin
        for (int i = 0; i < PAD; i++) begin
          pad_q[i] <= pad_d[i];
        end
      end
    end
    assign out_w = pad_q[PAD-1];
  end

  assign tp_peak   = out_w[DW-1];
  assign tp_fgv    = out_w[DW-2];
  assign tp_energy = out_w[E_W-1:0];

endmodule

// File: rtl/stf_strip_tpg.sv
// Strip trigger primitive: linearize, sum, filter, find peak, fixed latency.
module stf_strip_tpg #(
  parameter int unsigned NXTAL   = 5,
  parameter int unsigned ADC_W   = 12,
  parameter int unsigned COEF_W  = 6,
  parameter int unsigned PED_W   = 12,
  parameter int unsigned LIN_W   = 18,
  parameter int unsigned TAPS    = 5,
  parameter int unsigned TAP_W   = 8,
  parameter int unsigned E_W     = 18,
  parameter int unsigned LATENCY = stf_pkg::TP_LATENCY
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NXTAL*ADC_W-1:0]                    adc_in,
  input  logic [NXTAL*stf_pkg::GAIN_CODE_W-1:0]     gain_in,
  input  logic [stf_pkg::NUM_GAINS*COEF_W-1:0]      gain_coef,
  input  logic [NXTAL*PED_W-1:0]                    pedestal,
  input  logic [TAPS*TAP_W-1:0]                     fir_coef,
  input  logic [LIN_W-1:0]                          fgv_thresh,
  output logic [E_W-1:0]                            tp_energy,
  output logic                                      tp_peak,
  output logic                                      tp_fgv
);

  localparam int unsigned GSEL_W = stf_pkg::GAIN_CODE_W;
  localparam int unsigned SUM_W  = LIN_W + $clog2(NXTAL);
  localparam int unsigned Y_W    = SUM_W + 1 + TAP_W + $clog2(TAPS);
  localparam int unsigned PAD    = LATENCY - stf_pkg::CORE_STAGES;

  logic [NXTAL*LIN_W-1:0] lin_flat;
  logic [SUM_W-1:0]       strip_sum;
  logic [LIN_W-1:0]       strip_max;
  logic                   strip_fgv;
  logic signed [Y_W-1:0]  fir_y;
  logic                   fir_fgv;

  for (genvar i = 0; i < NXTAL; i++) begin : g_xtal
    stf_lin #(
      .ADC_W    (ADC_W),
      .COEF_W   (COEF_W),
      .PED_W    (PED_W),
      .LIN_W    (LIN_W),
      .GSEL_W   (GSEL_W),
      .NUM_GAINS(stf_pkg::NUM_GAINS)
    ) u_lin (
      .clk      (clk),
      .rst_n    (rst_n),
      .adc      (adc_in[i*ADC_W +: ADC_W]),
      .gsel     (gain_in[i*GSEL_W +: GSEL_W]),
      .gain_coef(gain_coef),
      .ped      (pedestal[i*PED_W +: PED_W]),
      .lin_q    (lin_flat[i*LIN_W +: LIN_W])
    );
  end

  stf_strip_sum #(
    .NXTAL(NXTAL),
    .LIN_W(LIN_W),
    .SUM_W(SUM_W)
  ) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .lin_flat  (lin_flat),
    .fgv_thresh(fgv_thresh),
    .sum_q     (strip_sum),
    .max_q     (strip_max),
    .fgv_q     (strip_fgv)
  );

  stf_fir #(
    .TAPS (TAPS),
    .TAP_W(TAP_W),
    .SUM_W(SUM_W),
    .Y_W  (Y_W)
  ) u_fir (
    .clk     (clk),
    .rst_n   (rst_n),
    .sum_in  (strip_sum),
    .fgv_in  (strip_fgv),
    .fir_coef(fir_coef),
    .y_q     (fir_y),
    .fgv_q   (fir_fgv)
  );

  stf_peak #(
    .Y_W(Y_W),
    .E_W(E_W),
    .PAD(PAD)
  ) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .y_in     (fir_y),
    .fgv_in   (fir_fgv),
    .tp_energy(tp_energy),
    .tp_peak  (tp_peak),
    .tp_fgv   (tp_fgv)
  );

endmodule

// File: rtl/stf_strip_tpg_chk.sv
module stf_strip_tpg_chk #(
  parameter int unsigned E_W   = 18,
  parameter int unsigned LIN_W = 18,
  parameter int unsigned SUM_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic [E_W-1:0]   tp_energy,
  input logic             tp_peak,
  input logic             tp_fgv,
  input logic [SUM_W-1:0] sum_q,
  input logic [LIN_W-1:0] max_q
);

  // R5
  peak_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_peak |=> !tp_peak);

  // R6
  energy_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_peak |-> (tp_energy == '0));

  // R7
  veto_with_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_fgv |-> tp_peak);

  // R2
  sum_covers_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q >= SUM_W'(max_q));

endmodule

bind stf_strip_tpg stf_strip_tpg_chk #(
  .E_W  (E_W),
  .LIN_W(LIN_W),
  .SUM_W(SUM_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tp_energy(tp_energy),
  .tp_peak  (tp_peak),
  .tp_fgv   (tp_fgv),
  .sum_q    (strip_sum),
  .max_q    (strip_max)
);

// File: tb/stf_strip_tpg_test.sv
module stf_strip_tpg_test;

  localparam int MAXS  = 400;
  localparam int FLUSH = 12;
  localparam longint EMAX = 262143;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [59:0] adc_in = '0;
  logic [9:0]  gain_in = '0;
  logic [23:0] gain_coef = '0;
  logic [59:0] pedestal = '0;
  logic [39:0] fir_coef = '0;
  logic [17:0] fgv_thresh = '0;
  logic [17:0] tp_energy;
  logic        tp_peak;
  logic        tp_fgv;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int sa [MAXS][5];
  int sg [MAXS][5];
  int nsamp;
  int gcf [4];
  int ped [5];
  int fc  [5];
  int thr;
  int unsigned seed = 32'h1234_5678;

  longint ys  [MAXS+FLUSH];
  longint ss  [MAXS+FLUSH];
  longint mxs [MAXS+FLUSH];

  always #4 clk = ~clk;

  stf_strip_tpg uut (
    .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .gain_in(gain_in),
    .gain_coef(gain_coef), .pedestal(pedestal), .fir_coef(fir_coef),
    .fgv_thresh(fgv_thresh), .tp_energy(tp_energy), .tp_peak(tp_peak),
    .tp_fgv(tp_fgv)
  );

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add_zero();
    for (int i = 0; i < 5; i++) begin sa[nsamp][i] = 0; sg[nsamp][i] = 0; end
    nsamp++;
  endtask

  task automatic add_one(input int x, input int a, input int g);
    for (int i = 0; i < 5; i++) begin sa[nsamp][i] = 0; sg[nsamp][i] = g; end
    sa[nsamp][x] = a;
    nsamp++;
  endtask

  task automatic add_all(input int a, input int g);
    for (int i = 0; i < 5; i++) begin sa[nsamp][i] = a; sg[nsamp][i] = g; end
    nsamp++;
  endtask

  task automatic run_phase(input string etag, input string ptag);
    int T;
    bit prev_pk;
    bit dbl;
    T = nsamp + FLUSH;
    // arithmetic model (R1, R2, R3)
    for (int n = 0; n < T; n++) begin
      ss[n] = 0; mxs[n] = 0;
      for (int i = 0; i < 5; i++) begin
        longint v;
        v = (n < nsamp) ? longint'(sa[n][i]) * gcf[sg[n][i]] - ped[i] : -longint'(ped[i]);
        if (v < 0) v = 0;
        if (v > EMAX) v = EMAX;
        ss[n] += v;
        if (v > mxs[n]) mxs[n] = v;
      end
      ys[n] = 0;
      for (int k = 0; k < 5; k++) if (n - k >= 0) ys[n] += longint'(fc[k]) * ss[n-k];
    end
    for (int k = 0; k < 4; k++) gain_coef[k*6 +: 6] = gcf[k][5:0];
    for (int i = 0; i < 5; i++) pedestal[i*12 +: 12] = ped[i][11:0];
    for (int k = 0; k < 5; k++) fir_coef[k*8 +: 8] = fc[k][7:0];
    fgv_thresh = thr[17:0];
    adc_in = '0; gain_in = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(tp_peak == 0 && tp_fgv == 0 && tp_energy == 0, "R9", longint'(tp_energy), 0);
    rst_n = 1'b1;
    prev_pk = 0; dbl = 0;
    for (int t = 0; t < T + 8; t++) begin
      @(negedge clk);
      if (t < 8) begin
        chk(tp_peak == 0, "R9", tp_peak, 0);
        chk(tp_energy == 0, "R9", longint'(tp_energy), 0);
      end else begin
        int n;
        bit epk;
        longint ee;
        n = t - 8;
        epk = ((n > 0 ? ys[n-1] : 0) < ys[n]) && (ys[n] >= (n + 1 < T ? ys[n+1] : 0));
        ee = 0;
        if (epk) ee = (ys[n] < 0) ? 0 : ((ys[n] > EMAX) ? EMAX : ys[n]);
        chk(tp_peak == epk, ptag, tp_peak, epk);
        chk(longint'(tp_energy) == ee, etag, longint'(tp_energy), ee);
        chk(tp_fgv == (epk && mxs[n] >= thr), "R7", tp_fgv, (epk && mxs[n] >= thr));
      end
      if (tp_peak && prev_pk) dbl = 1;
      prev_pk = tp_peak;
      for (int i = 0; i < 5; i++) begin
        adc_in[i*12 +: 12] = (t < nsamp) ? sa[t][i][11:0] : 12'd0;
        gain_in[i*2 +: 2]  = (t < nsamp) ? sg[t][i][1:0] : 2'd0;
      end
    end
    chk(dbl == 0, "R5", dbl, 0);
  endtask

  initial begin
    gcf = '{1, 5, 9, 33};
    // Phase R1: gain x crystal x amplitude impulses, identity filter; R8 timing
    ped = '{0, 0, 0, 0, 0}; fc = '{1, 0, 0, 0, 0}; thr = 262143;
    nsamp = 0;
    for (int g = 0; g < 4; g++)
      for (int x = 0; x < 5; x++)
        foreach (fc[j]) if (j < 3) begin
          add_one(x, (j == 0) ? 1 : (j == 1) ? 4095 : 1234, g);
          add_zero(); add_zero();
        end
    for (int g = 0; g < 4; g++) begin add_all(4095, g); add_zero(); add_zero(); end
    run_phase("R1", "R8");

    // Phase R2: pedestals with mixed gains, some below pedestal
    ped = '{10, 200, 3000, 0, 77};
    nsamp = 0;
    add_all(2, 0); add_zero(); add_zero();
    for (int r = 0; r < 60; r++) begin
      for (int i = 0; i < 5; i++) begin
        sa[nsamp][i] = int'(rnd() % 4096);
        sg[nsamp][i] = int'(rnd() % 4);
      end
      nsamp++;
      add_zero(); add_zero();
    end
    run_phase("R2", "R4");

    // Phase R4: plateaus and monotonic edges with identity filter
    ped = '{0, 0, 0, 0, 0};
    nsamp = 0;
    add_zero(); add_one(0, 10, 0); add_one(0, 10, 0); add_zero(); add_zero();
    add_one(1, 5, 0); add_one(1, 9, 0); add_one(1, 9, 0); add_one(1, 9, 0); add_one(1, 3, 0);
    add_zero(); add_zero();
    for (int a = 1; a < 8; a++) add_one(2, a * 100, 1);
    add_one(2, 700, 1); add_one(2, 50, 1); add_one(2, 60, 1); add_one(2, 55, 1);
    add_zero(); add_zero();
    run_phase("R6", "R4");

    // Phase R6: overflow clamp and negative-side clamp
    fc = '{127, -128, 0, 0, 0}; thr = 1000;
    nsamp = 0;
    add_zero(); add_all(4095, 3); add_zero(); add_zero(); add_zero();
    add_one(3, 300, 0); add_zero(); add_zero(); add_zero();
    run_phase("R6", "R4");

    // Phase R7: veto threshold edge cases
    fc = '{1, 0, 0, 0, 0}; thr = 5000;
    nsamp = 0;
    add_one(4, 1000, 1); add_zero(); add_zero();
    add_one(4, 999, 1);  add_zero(); add_zero();
    add_one(0, 1001, 1); add_zero(); add_zero();
    add_all(800, 1);     add_zero(); add_zero();
    add_one(2, 152, 3);  add_zero(); add_zero();
    run_phase("R7", "R4");

    // Phase R3: random stream through a shaping filter
    fc = '{-3, 10, 20, 10, -3}; ped = '{40, 40, 40, 40, 40}; thr = 30000;
    nsamp = 0;
    for (int r = 0; r < 300; r++) begin
      for (int i = 0; i < 5; i++) begin
        sa[nsamp][i] = ((rnd() % 4) == 0) ? int'(rnd() % 4096) : int'(rnd() % 64);
        sg[nsamp][i] = int'(rnd() % 4);
      end
      nsamp++;
    end
    run_phase("R3", "R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL R8: watchdog expired, actual hung expected finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule